// File: doc/BRIEF.md
# MSI Event Queue Controller

This block receives message-signalled interrupt writes and posts each accepted one as a two-word record into a per-queue ring in memory. A write carries an address, a 32-bit data value, a 16-bit requester ID and a flag that marks it as a 64-bit-address request. The address is compared against a programmed 32-bit or 64-bit window. The low 16 bits of the data select an MSI number, and a map table routes that number to a target queue. When that queue is active and has room, the record goes out through a single-cycle memory write port at the queue's tail slot, and the tail moves forward.

Each MSI carries a pending flag that the block sets when it posts the record. While the flag is set, further writes for that MSI are dropped until software clears it. Each queue is a ring with a head index that software advances and a tail index that hardware advances. The queue also has a one-hot state, an overflow flag and separate set and clear control registers. A queue raises its interrupt line while it is active and holds unread records.

Register access uses a 12-bit word address. Bits 11:8 select a group and bits 7:0 select the index within it. The groups are: 0 map entry, 1 MSI clear, 2 queue set, 3 queue clear, 4 queue state, 5 queue tail, 6 queue head, and 7 address windows. Reads are combinational from the address.

Top module: `msiq_ctrl`

## Requirements
- R1: A request with the 64-bit flag low matches when address bits 31:16 equal the 32-bit window. A request with the flag high matches when address bits 63:16 equal the 64-bit window. The 32-bit window is written and read in data bits 31:16 of group 7 index 0. The 64-bit window is written and read in data bits 63:16 of group 7 index 1. A non-matching request writes nothing.
- R2: A map entry (group 0, index = MSI number) reads back valid in bit 63, pending in bit 62 and the target queue in bits 5:0. A write sets the valid bit and the target queue only.
- R3: A matching request is dropped with no memory write if any of the following holds: its MSI number is not below NUM_MSI, its map entry is invalid, its pending flag is set, its target queue is not below NUM_Q, or its target queue is not active.
- R4: Word 0 of a record is laid out as follows. Bit 63 is 0. Bits 62:56 are the format/type: 0x2E for 32-bit and 0x3F for 64-bit, so the upper five bits are 0xB or 0xF. Bits 55:46 are the length 1, bits 45:32 are address bits 15:2, bits 31:16 are the requester ID, and bits 15:0 are data bits 15:0. Word 1 holds address bits 63:16 in bits 63:16 (zero for a 32-bit request) and data bits 31:16 in bits 15:0.
- R5: A posted record is written in the same cycle as the request, to the target queue at its current tail index. The tail then advances by one and wraps to 0 after Q_ENTRIES-1.
- R6: Posting sets the MSI's pending flag. Writing group 1 with bit 62 set clears the flag.
- R7: Queue state reads from group 4 bits 2:0 and is one-hot: idle 1, active 2, error 4. Writing the set register (group 2) with bit 44 set moves idle to active. Writing the clear register (group 3) with bit 44 set moves active to idle.
- R8: If advancing the tail would make it equal the head, nothing is written, the tail is unchanged, the overflow flag (tail register bit 57) is set, the queue enters the error state and the MSI's pending flag stays clear.
- R9: Bit 47 in the clear register moves error to idle. Bit 57 clears the overflow flag in the clear register and sets it in the set register.
- R10: A queue's interrupt output is high exactly while the queue is active and its head differs from its tail.
- R11: Head (group 6) and tail (group 5) indices sit in bits 6:0 and are writable by software. Reset leaves every queue idle with head, tail and overflow at zero, and every map entry zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register word address (group in 11:8, index in 7:0) |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_addr |
| msi_valid | input | 1 | MSI write request present |
| msi_is64 | input | 1 | Request uses a 64-bit address |
| msi_addr | input | 64 | Request address |
| msi_data | input | 32 | Request data; bits 15:0 give the MSI number |
| msi_rid | input | 16 | Requester ID |
| mem_we | output | 1 | Record write strobe |
| mem_queue | output | Q_W | Target queue of the record |
| mem_index | output | 7 | Slot index within the queue |
| mem_word0 | output | 64 | Record word 0 |
| mem_word1 | output | 64 | Record word 1 |
| q_irq | output | NUM_Q | Per-queue interrupt request |

## Verification
A corrupt pending flag shows at the ports on the next request for that MSI: a record is written that should have been dropped, or the reverse. A bad tail shows in the same cycle as a wrong mem_index, and one cycle after a post in the tail register read-back. A wrong ring state or full test appears as a missing record, as overflow bit 57, or as a state other than 1, 2 or 4 on the first post after the fault. The interrupt line exposes a head/tail mismatch combinationally, with no delay.

// File: rtl/msiq_pkg.sv
package msiq_pkg;

    localparam int IDX_W = 7;

    typedef enum logic [2:0] {
        QS_IDLE   = 3'b001,
        QS_ACTIVE = 3'b010,
        QS_ERROR  = 3'b100
    } qstate_e;

    localparam logic [3:0] GRP_MAP    = 4'h0;
    localparam logic [3:0] GRP_MCLR   = 4'h1;
    localparam logic [3:0] GRP_QSET   = 4'h2;
    localparam logic [3:0] GRP_QCLR   = 4'h3;
    localparam logic [3:0] GRP_QSTATE = 4'h4;
    localparam logic [3:0] GRP_TAIL   = 4'h5;
    localparam logic [3:0] GRP_HEAD   = 4'h6;
    localparam logic [3:0] GRP_WIN    = 4'h7;

    localparam int BIT_MAP_VALID = 63;
    localparam int BIT_PEND      = 62;
    localparam int BIT_OFLOW     = 57;
    localparam int BIT_E2I       = 47;
    localparam int BIT_ENABLE    = 44;

    localparam logic [4:0] KIND_MSI32 = 5'h0B;
    localparam logic [4:0] KIND_MSI64 = 5'h0F;

    typedef struct packed {
        logic       valid;
        logic       pend;
        logic [5:0] qnum;
    } map_ent_t;

    typedef struct packed {
        logic        rsv;
        logic [6:0]  fmt_type;
        logic [9:0]  len;
        logic [13:0] addr_lo;
        logic [15:0] rid;
        logic [15:0] data_lo;
    } word0_t;

    typedef struct packed {
        logic [47:0] addr_hi;
        logic [15:0] data_hi;
    } word1_t;

    function automatic logic [IDX_W-1:0] idx_step(input logic [IDX_W-1:0] i,
                                                  input int unsigned n);
        if (32'(i) >= n - 1) return '0;
        return i + 1'b1;
    endfunction

endpackage

// File: rtl/msiq_decode.sv
module msiq_decode
    import msiq_pkg::*;
(
    input  logic [63:0] addr,
    input  logic        is64,
    input  logic [15:0] win32,
    input  logic [47:0] win64,
    input  logic [15:0] rid,
    input  logic [31:0] data,
    output logic        hit,
    output word0_t      word0,
    output word1_t      word1
);
    always_comb begin
        hit = is64 ? (addr[63:16] == win64) : (addr[31:16] == win32);

        word0.rsv      = 1'b0;
        word0.fmt_type = is64 ? {KIND_MSI64, 2'b11} : {KIND_MSI32, 2'b10};
        word0.len      = 10'd1;
        word0.addr_lo  = addr[15:2];
        word0.rid      = rid;
        word0.data_lo  = data[15:0];

        word1.addr_hi  = is64 ? addr[63:16] : 48'd0;
        word1.data_hi  = data[31:16];
    end
endmodule

// File: rtl/msiq_map.sv
module msiq_map
    import msiq_pkg::*;
#(
    parameter int NUM_MSI = 16,
    localparam int MSI_W = (NUM_MSI > 1) ? $clog2(NUM_MSI) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             map_we,
    input  logic             clr_we,
    input  logic [MSI_W-1:0] reg_idx,
    input  logic             wr_valid,
    input  logic             wr_clr_pend,
    input  logic [5:0]       wr_qnum,
    input  logic             post,
    input  logic [MSI_W-1:0] post_idx,
    input  logic [MSI_W-1:0] lk_idx,
    output map_ent_t         lk_ent,
    output map_ent_t         rd_ent
);
    logic [NUM_MSI-1:0] valid_q;
    logic [NUM_MSI-1:0] pend_q;
    logic [5:0]         qnum_q [NUM_MSI];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            pend_q  <= '0;
            for (int i = 0; i < NUM_MSI; i++) qnum_q[i] <= '0;
        end else begin
            if (post) pend_q[post_idx] <= 1'b1;
            if (clr_we && wr_clr_pend) pend_q[reg_idx] <= 1'b0;
            if (map_we) begin
                valid_q[reg_idx] <= wr_valid;
                qnum_q[reg_idx]  <= wr_qnum;
            end
        end
    end

    always_comb begin
        lk_ent = '{valid: valid_q[lk_idx], pend: pend_q[lk_idx], qnum: qnum_q[lk_idx]};
        rd_ent = '{valid: valid_q[reg_idx], pend: pend_q[reg_idx], qnum: qnum_q[reg_idx]};
    end

    // R3: a record is only posted for a valid, non-pending MSI
    a_r3_no_repost: assert property (@(posedge clk) disable iff (rst)
        post |-> (valid_q[post_idx] && !pend_q[post_idx]));

    // R6: posting leaves the MSI pending on the next cycle
    a_r6_pend_set: assert property (@(posedge clk) disable iff (rst)
        (post && !(clr_we && wr_clr_pend && reg_idx == post_idx))
        |=> pend_q[$past(post_idx)]);
endmodule

// File: rtl/msiq_ring.sv
module msiq_ring
    import msiq_pkg::*;
#(
    parameter int Q_ENTRIES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             post,
    input  logic             ovf,
    input  logic             set_we,
    input  logic             clr_we,
    input  logic             head_we,
    input  logic             tail_we,
    input  logic             w_en,
    input  logic             w_oflow,
    input  logic             w_e2i,
    input  logic [IDX_W-1:0] w_idx,
    output qstate_e          state,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic             oflow,
    output logic             full,
    output logic             irq
);
    logic [IDX_W-1:0] tail_nxt;

    always_comb begin
        tail_nxt = idx_step(tail, Q_ENTRIES);
        full     = (tail_nxt == head);
        irq      = (state == QS_ACTIVE) && (head != tail);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= QS_IDLE;
            head  <= '0;
            tail  <= '0;
            oflow <= 1'b0;
        end else begin
            if (post) tail <= tail_nxt;
            if (ovf) begin
                oflow <= 1'b1;
                state <= QS_ERROR;
            end
            if (set_we) begin
                if (w_en && state == QS_IDLE) state <= QS_ACTIVE;
                if (w_oflow) oflow <= 1'b1;
            end
            if (clr_we) begin
                if (w_en && state == QS_ACTIVE) state <= QS_IDLE;
                if (w_e2i && state == QS_ERROR) state <= QS_IDLE;
                if (w_oflow) oflow <= 1'b0;
            end
            if (head_we) head <= w_idx;
            if (tail_we) tail <= w_idx;
        end
    end

    // R7: state encoding stays one-hot
    a_r7_state_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot(state));

    // R5: only an active queue with room receives a record
    a_r5_post_active: assert property (@(posedge clk) disable iff (rst)
        post |-> (state == QS_ACTIVE && !full));

    // R8: an overflow lands the queue in error with the flag set
    a_r8_ovf_error: assert property (@(posedge clk) disable iff (rst)
        (ovf && !clr_we) |=> (state == QS_ERROR && oflow));
endmodule

// File: rtl/msiq_ctrl.sv
module msiq_ctrl
    import msiq_pkg::*;
#(
    parameter int NUM_MSI   = 16,
    parameter int NUM_Q     = 4,
    parameter int Q_ENTRIES = 8,
    localparam int MSI_W = (NUM_MSI > 1) ? $clog2(NUM_MSI) : 1,
    localparam int Q_W   = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [11:0]      reg_addr,
    input  logic [63:0]      reg_wdata,
    output logic [63:0]      reg_rdata,
    input  logic             msi_valid,
    input  logic             msi_is64,
    input  logic [63:0]      msi_addr,
    input  logic [31:0]      msi_data,
    input  logic [15:0]      msi_rid,
    output logic             mem_we,
    output logic [Q_W-1:0]   mem_queue,
    output logic [IDX_W-1:0] mem_index,
    output logic [63:0]      mem_word0,
    output logic [63:0]      mem_word1,
    output logic [NUM_Q-1:0] q_irq
);
    logic [3:0] grp;
    logic [7:0] ridx;
    assign grp  = reg_addr[11:8];
    assign ridx = reg_addr[7:0];

    // address windows
    logic [15:0] win32_q;
    logic [47:0] win64_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            win32_q <= '0;
            win64_q <= '0;
        end else if (reg_we && grp == GRP_WIN) begin
            if (ridx == 8'd0) win32_q <= reg_wdata[31:16];
            if (ridx == 8'd1) win64_q <= reg_wdata[63:16];
        end
    end

    // request decode
    logic   hit;
    word0_t w0;
    word1_t w1;
    msiq_decode u_decode (
        .addr (msi_addr), .is64 (msi_is64), .win32 (win32_q), .win64 (win64_q),
        .rid  (msi_rid),  .data (msi_data), .hit (hit), .word0 (w0), .word1 (w1)
    );

    // map lookup
    logic [15:0]      msi_num;
    logic             num_ok;
    logic [MSI_W-1:0] lk_idx;
    map_ent_t         lk_ent, rd_ent;
    logic             reg_msi_ok;
    logic             post, ovf, eligible;
    logic [Q_W-1:0]   tq;
    logic             q_ok;

    assign msi_num    = msi_data[15:0];
    assign num_ok     = (32'(msi_num) < NUM_MSI);
    assign lk_idx     = msi_num[MSI_W-1:0];
    assign reg_msi_ok = (32'(ridx) < NUM_MSI);

    msiq_map #(.NUM_MSI(NUM_MSI)) u_map (
        .clk         (clk),
        .rst         (rst),
        .map_we      (reg_we && grp == GRP_MAP && reg_msi_ok),
        .clr_we      (reg_we && grp == GRP_MCLR && reg_msi_ok),
        .reg_idx     (ridx[MSI_W-1:0]),
        .wr_valid    (reg_wdata[BIT_MAP_VALID]),
        .wr_clr_pend (reg_wdata[BIT_PEND]),
        .wr_qnum     (reg_wdata[5:0]),
        .post        (post),
        .post_idx    (lk_idx),
        .lk_idx      (lk_idx),
        .lk_ent      (lk_ent),
        .rd_ent      (rd_ent)
    );

    // queue rings
    qstate_e          q_state [NUM_Q];
    logic [IDX_W-1:0] q_head  [NUM_Q];
    logic [IDX_W-1:0] q_tail  [NUM_Q];
    logic [NUM_Q-1:0] q_oflow, q_full;

    assign tq   = lk_ent.qnum[Q_W-1:0];
    assign q_ok = (32'(lk_ent.qnum) < NUM_Q);

    always_comb begin
        eligible = msi_valid && hit && num_ok && lk_ent.valid && !lk_ent.pend
                   && q_ok && (q_state[tq] == QS_ACTIVE);
        post     = eligible && !q_full[tq];
        ovf      = eligible &&  q_full[tq];
    end

    for (genvar q = 0; q < NUM_Q; q++) begin : g_ring
        logic sel_q;
        assign sel_q = (32'(ridx) == q);
        msiq_ring #(.Q_ENTRIES(Q_ENTRIES)) u_ring (
            .clk     (clk),
            .rst     (rst),
            .post    (post && 32'(tq) == q),
            .ovf     (ovf  && 32'(tq) == q),
            .set_we  (reg_we && grp == GRP_QSET && sel_q),
            .clr_we  (reg_we && grp == GRP_QCLR && sel_q),
            .head_we (reg_we && grp == GRP_HEAD && sel_q),
            .tail_we (reg_we && grp == GRP_TAIL && sel_q),
            .w_en    (reg_wdata[BIT_ENABLE]),
            .w_oflow (reg_wdata[BIT_OFLOW]),
            .w_e2i   (reg_wdata[BIT_E2I]),
            .w_idx   (reg_wdata[IDX_W-1:0]),
            .state   (q_state[q]),
            .head    (q_head[q]),
            .tail    (q_tail[q]),
            .oflow   (q_oflow[q]),
            .full    (q_full[q]),
            .irq     (q_irq[q])
        );
    end

    // memory write port
    always_comb begin
        mem_we    = post;
        mem_queue = tq;
        mem_index = q_tail[tq];
        mem_word0 = w0;
        mem_word1 = w1;
    end

    // register read
    logic [Q_W-1:0] rq;
    logic           rq_ok;
    assign rq    = ridx[Q_W-1:0];
    assign rq_ok = (32'(ridx) < NUM_Q);

    always_comb begin
        reg_rdata = '0;
        case (grp)
            GRP_MAP: if (reg_msi_ok) begin
                reg_rdata[BIT_MAP_VALID] = rd_ent.valid;
                reg_rdata[BIT_PEND]      = rd_ent.pend;
                reg_rdata[5:0]           = rd_ent.qnum;
            end
            GRP_MCLR: if (reg_msi_ok) reg_rdata[BIT_PEND] = rd_ent.pend;
            GRP_QSET, GRP_QCLR: if (rq_ok) begin
                reg_rdata[BIT_OFLOW]  = q_oflow[rq];
                reg_rdata[BIT_ENABLE] = (q_state[rq] == QS_ACTIVE);
            end
            GRP_QSTATE: if (rq_ok) reg_rdata[2:0] = q_state[rq];
            GRP_TAIL: if (rq_ok) begin
                reg_rdata[BIT_OFLOW]   = q_oflow[rq];
                reg_rdata[IDX_W-1:0]   = q_tail[rq];
            end
            GRP_HEAD: if (rq_ok) reg_rdata[IDX_W-1:0] = q_head[rq];
            GRP_WIN: begin
                if (ridx == 8'd0) reg_rdata[31:16] = win32_q;
                if (ridx == 8'd1) reg_rdata[63:16] = win64_q;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: tb/test_msiq_ctrl.sv
module test_msiq_ctrl;
    localparam int NQ = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        msi_valid = 1'b0;
    logic        msi_is64 = 1'b0;
    logic [63:0] msi_addr = '0;
    logic [31:0] msi_data = '0;
    logic [15:0] msi_rid = '0;
    logic        mem_we;
    logic [1:0]  mem_queue;
    logic [6:0]  mem_index;
    logic [63:0] mem_word0, mem_word1;
    logic [NQ-1:0] q_irq;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    msiq_ctrl #(.NUM_MSI(16), .NUM_Q(NQ), .Q_ENTRIES(8)) i_msiq_ctrl (
        .clk (clk), .rst (rst), .reg_we (reg_we), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .msi_valid (msi_valid),
        .msi_is64 (msi_is64), .msi_addr (msi_addr), .msi_data (msi_data),
        .msi_rid (msi_rid), .mem_we (mem_we), .mem_queue (mem_queue),
        .mem_index (mem_index), .mem_word0 (mem_word0), .mem_word1 (mem_word1),
        .q_irq (q_irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [63:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic send(input bit is64, input logic [63:0] a, input logic [31:0] d,
                        input logic [15:0] rid, output logic we, output logic [1:0] q,
                        output logic [6:0] idx, output logic [63:0] w0, output logic [63:0] w1);
        @(negedge clk);
        msi_valid = 1'b1; msi_is64 = is64; msi_addr = a; msi_data = d; msi_rid = rid;
        #1;
        we = mem_we; q = mem_queue; idx = mem_index; w0 = mem_word0; w1 = mem_word1;
        @(negedge clk);
        msi_valid = 1'b0;
    endtask

    function automatic logic [63:0] exp_w0(input bit is64, input logic [63:0] a,
                                           input logic [15:0] rid, input logic [31:0] d);
        return {1'b0, (is64 ? 7'h3F : 7'h2E), 10'd1, a[15:2], rid, d[15:0]};
    endfunction

    localparam logic [63:0] BIT63 = 64'h1 << 63;
    localparam logic [63:0] BIT62 = 64'h1 << 62;
    localparam logic [63:0] BIT57 = 64'h1 << 57;
    localparam logic [63:0] BIT47 = 64'h1 << 47;
    localparam logic [63:0] BIT44 = 64'h1 << 44;
    localparam logic [63:0] A32   = 64'h0000_0000_FEE0_0010;
    localparam logic [63:0] A64   = 64'h0000_1234_5678_0020;

    logic [63:0] r, w0, w1;
    logic        we;
    logic [1:0]  q;
    logic [6:0]  idx;

    task automatic t_reset();
        rd(12'h401, r); chk("R11 reset state", r, 64'd1);
        rd(12'h501, r); chk("R11 reset tail", r, 64'd0);
        rd(12'h601, r); chk("R11 reset head", r, 64'd0);
        rd(12'h003, r); chk("R11 reset map", r, 64'd0);
        chk("R11 reset irq", 64'(q_irq), 64'd0);
    endtask

    task automatic t_setup();
        wr(12'h700, 64'h0000_0000_FEE0_0000);
        wr(12'h701, 64'h0000_1234_5678_0000);
        rd(12'h700, r); chk("R1 win32 readback", r, 64'h0000_0000_FEE0_0000);
        rd(12'h701, r); chk("R1 win64 readback", r, 64'h0000_1234_5678_0000);
        wr(12'h003, BIT63 | BIT62 | 64'd1);
        rd(12'h003, r); chk("R2 map readback", r, BIT63 | 64'd1);
        wr(12'h201, BIT44);
        rd(12'h401, r); chk("R7 enable to active", r, 64'd2);
    endtask

    task automatic t_post32();
        send(1'b0, A32, 32'h0005_0003, 16'hABCD, we, q, idx, w0, w1);
        chk("R5 post write", 64'(we), 64'd1);
        chk("R5 post queue", 64'(q), 64'd1);
        chk("R5 post index", 64'(idx), 64'd0);
        chk("R4 word0 32-bit", w0, exp_w0(1'b0, A32, 16'hABCD, 32'h0005_0003));
        chk("R4 word1 32-bit", w1, 64'h0000_0000_0000_0005);
        rd(12'h501, r); chk("R5 tail advanced", r, 64'd1);
        chk("R10 irq pending", 64'(q_irq), 64'b0010);
        rd(12'h003, r); chk("R6 pend set", r, BIT63 | BIT62 | 64'd1);
    endtask

    task automatic t_drops();
        send(1'b0, A32, 32'h0000_0003, 16'h1, we, q, idx, w0, w1);
        chk("R3 pending blocks repost", 64'(we), 64'd0);
        wr(12'h103, BIT62);
        rd(12'h003, r); chk("R6 clear pending", r, BIT63 | 64'd1);
        send(1'b0, 64'h0000_0000_FEE1_0010, 32'h0000_0003, 16'h1, we, q, idx, w0, w1);
        chk("R1 window mismatch", 64'(we), 64'd0);
        send(1'b1, A32, 32'h0000_0003, 16'h1, we, q, idx, w0, w1);
        chk("R1 64-bit window mismatch", 64'(we), 64'd0);
        send(1'b0, A32, 32'h0000_0004, 16'h1, we, q, idx, w0, w1);
        chk("R3 invalid map", 64'(we), 64'd0);
        wr(12'h005, BIT63 | 64'd2);
        send(1'b0, A32, 32'h0000_0005, 16'h1, we, q, idx, w0, w1);
        chk("R3 inactive queue", 64'(we), 64'd0);
        send(1'b0, A32, 32'h0000_0013, 16'h1, we, q, idx, w0, w1);
        chk("R3 msi number out of range", 64'(we), 64'd0);
        rd(12'h501, r); chk("R3 tail unchanged by drops", r, 64'd1);
    endtask

    task automatic t_post64();
        wr(12'h006, BIT63 | 64'd1);
        send(1'b1, A64, 32'hBEEF_0006, 16'h0042, we, q, idx, w0, w1);
        chk("R5 64-bit write", 64'(we), 64'd1);
        chk("R5 64-bit index", 64'(idx), 64'd1);
        chk("R4 word0 64-bit", w0, exp_w0(1'b1, A64, 16'h0042, 32'hBEEF_0006));
        chk("R4 word1 64-bit", w1, 64'h0000_1234_5678_BEEF);
        wr(12'h601, 64'd2);
        rd(12'h601, r); chk("R11 head write", r, 64'd2);
        chk("R10 irq off when head equals tail", 64'(q_irq), 64'd0);
    endtask

    task automatic t_wrap();
        wr(12'h501, 64'd7);
        wr(12'h601, 64'd3);
        wr(12'h106, BIT62);
        send(1'b1, A64, 32'h0000_0006, 16'h7, we, q, idx, w0, w1);
        chk("R5 write at last slot", {57'd0, we, idx}, {57'd0, 1'b1, 7'd7});
        rd(12'h501, r); chk("R5 tail wraps", r, 64'd0);
    endtask

    task automatic t_overflow();
        wr(12'h601, 64'd1);
        wr(12'h106, BIT62);
        send(1'b1, A64, 32'h0000_0006, 16'h7, we, q, idx, w0, w1);
        chk("R8 no write when full", 64'(we), 64'd0);
        rd(12'h501, r); chk("R8 overflow flag, tail kept", r, BIT57);
        rd(12'h401, r); chk("R8 error state", r, 64'd4);
        rd(12'h006, r); chk("R8 pending stays clear", r, BIT63 | 64'd1);
        chk("R10 irq off in error", 64'(q_irq), 64'd0);
    endtask

    task automatic t_recover();
        wr(12'h301, BIT57 | BIT47);
        rd(12'h501, r); chk("R9 overflow cleared", r, 64'd0);
        rd(12'h401, r); chk("R9 error to idle", r, 64'd1);
        wr(12'h201, BIT57);
        rd(12'h501, r); chk("R9 overflow set by set reg", r, BIT57);
        wr(12'h201, BIT44);
        rd(12'h401, r); chk("R7 re-enable", r, 64'd2);
        chk("R10 irq active with head!=tail", 64'(q_irq), 64'b0010);
        wr(12'h301, BIT44);
        rd(12'h401, r); chk("R7 disable to idle", r, 64'd1);
        chk("R10 irq off when idle", 64'(q_irq), 64'd0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_setup();
        t_post32();
        t_drops();
        t_post64();
        t_wrap();
        t_overflow();
        t_recover();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule